// File: doc/BRIEF.md
# DMA Descriptor Fetch and Load Unit

This unit prepares a DMA channel for its next work unit. A start pulse arrives when software enables the channel or when the previous unit ends. The unit then checks the channel's configuration word. If the flow mode calls for it, the unit reads a descriptor of 16-bit words from memory through a single request/acknowledge read port. It hands each word to the channel's parameter registers through a one-hot load strobe. It finishes by issuing the starting values for the channel's running state.

The flow mode controls three things: where the descriptor comes from, how many words it may hold, and which parameter register each word lands in. Stop and autobuffer modes fetch nothing. Array mode reads from the current descriptor pointer. The two linked-list modes read from the next descriptor pointer and first refill one or both halves of that pointer. An illegal descriptor length or an undefined flow code is refused without any fetch. A start address that does not suit the element size is reported through the same error flag.

Moving the data and stepping the address belong to the transfer engine beside this unit.

Top module: `dma_desc_loader`

## Requirements
- R1: After reset, mem_req_o, prm_we_o, cur_we_o, done_o and err_o are all 0.
- R2: The configuration word holds the flow code in bits [14:12] (0 stop, 1 autobuffer, 2 array, 3 small list, 4 large list, 5 to 7 undefined) and the word count in bits [11:8]. The legal counts are: 0 for stop and autobuffer, 1 to 7 for array, 1 to 8 for small list, 1 to 9 for large list. Any other combination makes done_o and err_o rise one cycle after start_i, with no memory request and no cur_we_o.
- R3: A legal start with a count of 0 issues no memory request. It raises done_o and cur_we_o two cycles after start_i.
- R4: Array mode reads from cur_ptr_i and the list modes read from next_ptr_i. Word k is read at base + 2k, one request at a time. mem_req_o and mem_addr_o hold steady until mem_ack_i is seen.
- R5: Each acknowledged word appears on prm_wdata_o in the following cycle, with one bit of prm_we_o set. Bit order: 0 next-pointer low, 1 next-pointer high, 2 start-address low, 3 start-address high, 4 config, 5 X count, 6 X modify, 7 Y count, 8 Y modify. The words map as follows. Large list: word k goes to bit k. Small list: word 0 goes to bit 0 and word k>0 goes to bit k+1. Array: word k goes to bit k+2.
- R6: With cur_we_o, cur_desc_ptr_o and cur_addr_o carry the next pointer and start address as finally loaded. cur_x_o and cur_y_o carry the final X and Y counts, with a count of 0 issued as 0xFFFF.
- R7: Bits [3:2] of the start configuration choose the element size: 2'b10 is 4 bytes, 2'b01 is 2 bytes, anything else is 1 byte. A final start address that is not a multiple of the element size sets err_o together with done_o. cur_we_o is still issued.
- R8: A start_i that arrives while a descriptor is in progress is ignored. The configuration, pointers and counts are captured when a start is accepted.
- R9: err_o keeps its value until the next accepted start, which clears it unless that start itself fails.
- R10: done_o is a single-cycle pulse. When the descriptor was fetched, it comes one cycle after the last word's strobe. cur_we_o is only ever high together with done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a descriptor load |
| cfg_i | input | 16 | Channel configuration word |
| next_ptr_i | input | 32 | Next descriptor pointer |
| cur_ptr_i | input | 32 | Current descriptor pointer |
| start_addr_i | input | 32 | Programmed start address |
| x_count_i | input | 16 | Programmed X count |
| y_count_i | input | 16 | Programmed Y count |
| mem_req_o | output | 1 | Descriptor read request |
| mem_addr_o | output | 32 | Descriptor read byte address |
| mem_ack_i | input | 1 | Read acknowledge, data valid |
| mem_rdata_i | input | 16 | Read data |
| prm_we_o | output | 9 | One-hot parameter register load strobe |
| prm_wdata_o | output | 16 | Value for the strobed register |
| cur_we_o | output | 1 | Load strobe for the current-state registers |
| cur_desc_ptr_o | output | 32 | Initial current descriptor pointer |
| cur_addr_o | output | 32 | Initial current address |
| cur_x_o | output | 16 | Initial current X count |
| cur_y_o | output | 16 | Initial current Y count |
| err_o | output | 1 | Configuration or alignment error |
| done_o | output | 1 | Load finished pulse |

## Verification
Each result has its own due cycle after start_i:
- A refused configuration shows done_o and err_o at the first falling edge after start_i has been sampled.
- A zero-length load completes at the second falling edge.
- A fetched word's strobe follows its acknowledge by exactly one cycle, and done_o follows the last strobe by one more.

The bench drives start_i and acknowledges at a falling edge and reads every output at the next falling edge. It counts the cycles since the start, so each of these due cycles is checked exactly. Random acknowledge delays stretch the fetch, but they do not change the strobe-to-acknowledge or done-to-last-strobe offsets.

// File: rtl/dma_desc_pkg.sv
package dma_desc_pkg;
  localparam int unsigned HW     = 16;
  localparam int unsigned AW     = 2 * HW;
  localparam int unsigned NT     = 9;
  localparam int unsigned IW     = 4;
  localparam int unsigned NS     = 6;
  localparam int unsigned FL_LSB = 12;
  localparam int unsigned ND_LSB = 8;
  localparam int unsigned WS_LSB = 2;

  typedef enum logic [2:0] {
    FLOW_STOP  = 3'd0,
    FLOW_AUTO  = 3'd1,
    FLOW_ARRAY = 3'd2,
    FLOW_SMALL = 3'd3,
    FLOW_LARGE = 3'd4
  } flow_e;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_LOAD} state_e;

  localparam logic [IW-1:0] T_XCNT = 4'd5;
  localparam logic [IW-1:0] T_YCNT = 4'd7;

  function automatic logic [IW-1:0] nd_limit(input logic [2:0] fl);
    case (fl)
      FLOW_ARRAY: nd_limit = 4'd7;
      FLOW_SMALL: nd_limit = 4'd8;
      FLOW_LARGE: nd_limit = 4'd9;
      default:    nd_limit = 4'd0;
    endcase
  endfunction
endpackage

// File: rtl/dma_desc_cfg_check.sv
module dma_desc_cfg_check
  import dma_desc_pkg::*;
(
  input  logic [2:0]    flow_i,
  input  logic [IW-1:0] nd_i,
  input  logic [1:0]    ws_i,
  output logic          legal_o,
  output logic          from_cur_o,
  output logic [1:0]    amask_o
);
  logic [IW-1:0] lim;

  always_comb begin
    lim = nd_limit(flow_i);
    case (flow_i)
      FLOW_STOP, FLOW_AUTO:               legal_o = (nd_i == '0);
      FLOW_ARRAY, FLOW_SMALL, FLOW_LARGE: legal_o = (nd_i != '0) && (nd_i <= lim);
      default:                            legal_o = 1'b0;
    endcase
    from_cur_o = (flow_i == FLOW_ARRAY);
    case (ws_i)
      2'b10:   amask_o = 2'b11;
      2'b01:   amask_o = 2'b01;
      default: amask_o = 2'b00;
    endcase
  end
endmodule

// File: rtl/dma_desc_word_map.sv
module dma_desc_word_map
  import dma_desc_pkg::*;
(
  input  logic [2:0]    flow_i,
  input  logic [IW-1:0] idx_i,
  output logic [IW-1:0] tgt_o
);
  always_comb begin
    case (flow_i)
      FLOW_SMALL: tgt_o = (idx_i == '0) ? '0 : idx_i + IW'(1);
      FLOW_ARRAY: tgt_o = idx_i + IW'(2);
      default:    tgt_o = idx_i;
    endcase
  end
endmodule

// File: rtl/dma_desc_shadow.sv
module dma_desc_shadow
  import dma_desc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic [NS*HW-1:0] cap_vec_i,
  input  logic             wr_i,
  input  logic [IW-1:0]    tgt_i,
  input  logic [HW-1:0]    wdata_i,
  output logic [NS*HW-1:0] vec_o
);
  // slots 0..3 track pointer/address halves, 4 X count, 5 Y count
  function automatic logic [IW-1:0] slot_tgt(input int s);
    if (s < 4)       slot_tgt = IW'(s);
    else if (s == 4) slot_tgt = T_XCNT;
    else             slot_tgt = T_YCNT;
  endfunction

  for (genvar s = 0; s < NS; s++) begin : g_slot
    logic [HW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            q <= '0;
      else if (cap_i)                         q <= cap_vec_i[s*HW +: HW];
      else if (wr_i && tgt_i == slot_tgt(s))  q <= wdata_i;
    end
    assign vec_o[s*HW +: HW] = q;
  end
endmodule

// File: rtl/dma_desc_loader.sv
module dma_desc_loader
  import dma_desc_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [HW-1:0] cfg_i,
  input  logic [AW-1:0] next_ptr_i,
  input  logic [AW-1:0] cur_ptr_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic [HW-1:0] x_count_i,
  input  logic [HW-1:0] y_count_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_ack_i,
  input  logic [HW-1:0] mem_rdata_i,
  output logic [NT-1:0] prm_we_o,
  output logic [HW-1:0] prm_wdata_o,
  output logic          cur_we_o,
  output logic [AW-1:0] cur_desc_ptr_o,
  output logic [AW-1:0] cur_addr_o,
  output logic [HW-1:0] cur_x_o,
  output logic [HW-1:0] cur_y_o,
  output logic          err_o,
  output logic          done_o
);
  state_e        st_q;
  logic [2:0]    flow_q;
  logic [IW-1:0] nd_q, idx_q, tgt;
  logic [1:0]    amask_q, amask;
  logic [AW-1:0] addr_q;
  logic          legal, from_cur, accept, fetch_hit;
  logic [NT-1:0] prm_we_q;
  logic [HW-1:0] prm_wdata_q;
  logic          cur_we_q, err_q, done_q;
  logic [AW-1:0] cur_desc_q, cur_addr_q;
  logic [HW-1:0] cur_x_q, cur_y_q;
  logic [NS*HW-1:0] shd;
  logic [AW-1:0] shd_ndp, shd_sa;
  logic [HW-1:0] shd_xc, shd_yc;
  logic          unused_cfg;

  assign unused_cfg = ^{cfg_i[15], cfg_i[7:4], cfg_i[1:0]};
  assign accept     = start_i && (st_q == S_IDLE);
  assign fetch_hit  = (st_q == S_FETCH) && mem_ack_i;

  dma_desc_cfg_check u_check (
    .flow_i     (cfg_i[FL_LSB +: 3]),
    .nd_i       (cfg_i[ND_LSB +: IW]),
    .ws_i       (cfg_i[WS_LSB +: 2]),
    .legal_o    (legal),
    .from_cur_o (from_cur),
    .amask_o    (amask)
  );

  dma_desc_word_map u_map (
    .flow_i (flow_q),
    .idx_i  (idx_q),
    .tgt_o  (tgt)
  );

  dma_desc_shadow u_shadow (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cap_i     (accept),
    .cap_vec_i ({y_count_i, x_count_i, start_addr_i, next_ptr_i}),
    .wr_i      (fetch_hit),
    .tgt_i     (tgt),
    .wdata_i   (mem_rdata_i),
    .vec_o     (shd)
  );

  assign shd_ndp = shd[0 +: AW];
  assign shd_sa  = shd[AW +: AW];
  assign shd_xc  = shd[2*AW +: HW];
  assign shd_yc  = shd[2*AW+HW +: HW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= S_IDLE;
      flow_q      <= '0;
      nd_q        <= '0;
      idx_q       <= '0;
      amask_q     <= '0;
      addr_q      <= '0;
      prm_we_q    <= '0;
      prm_wdata_q <= '0;
      cur_we_q    <= 1'b0;
      cur_desc_q  <= '0;
      cur_addr_q  <= '0;
      cur_x_q     <= '0;
      cur_y_q     <= '0;
      err_q       <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      prm_we_q <= '0;
      cur_we_q <= 1'b0;
      done_q   <= 1'b0;
      case (st_q)
        S_IDLE: begin
          if (start_i) begin
            flow_q  <= cfg_i[FL_LSB +: 3];
            nd_q    <= cfg_i[ND_LSB +: IW];
            amask_q <= amask;
            idx_q   <= '0;
            addr_q  <= from_cur ? cur_ptr_i : next_ptr_i;
            if (!legal) begin
              err_q  <= 1'b1;
              done_q <= 1'b1;
            end else begin
              err_q <= 1'b0;
              st_q  <= (cfg_i[ND_LSB +: IW] == '0) ? S_LOAD : S_FETCH;
            end
          end
        end
        S_FETCH: begin
          if (mem_ack_i) begin
            prm_we_q    <= NT'(1) << tgt;
            prm_wdata_q <= mem_rdata_i;
            idx_q       <= idx_q + IW'(1);
            addr_q      <= addr_q + AW'(2);
            if (idx_q == nd_q - IW'(1)) st_q <= S_LOAD;
          end
        end
        S_LOAD: begin
          cur_we_q   <= 1'b1;
          done_q     <= 1'b1;
          cur_desc_q <= shd_ndp;
          cur_addr_q <= shd_sa;
          cur_x_q    <= (shd_xc == '0) ? '1 : shd_xc;
          cur_y_q    <= (shd_yc == '0) ? '1 : shd_yc;
          err_q      <= |(shd_sa[1:0] & amask_q);
          st_q       <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign mem_req_o      = (st_q == S_FETCH);
  assign mem_addr_o     = addr_q;
  assign prm_we_o       = prm_we_q;
  assign prm_wdata_o    = prm_wdata_q;
  assign cur_we_o       = cur_we_q;
  assign cur_desc_ptr_o = cur_desc_q;
  assign cur_addr_o     = cur_addr_q;
  assign cur_x_o        = cur_x_q;
  assign cur_y_o        = cur_y_q;
  assign err_o          = err_q;
  assign done_o         = done_q;
endmodule

// File: rtl/dma_desc_loader_chk.sv
module dma_desc_loader_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        mem_req_o,
  input logic        mem_ack_i,
  input logic [31:0] mem_addr_o,
  input logic [8:0]  prm_we_o,
  input logic        cur_we_o,
  input logic [15:0] cur_x_o,
  input logic [15:0] cur_y_o,
  input logic        done_o
);
  // R4
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o));
  // R4
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ack_i |=> !mem_req_o || (mem_addr_o == $past(mem_addr_o) + 32'd2));
  // R5
  strobe_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(prm_we_o));
  // R5
  strobe_after_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|prm_we_o) |-> $past(mem_req_o && mem_ack_i));
  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> !done_o);
  // R10
  cur_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_we_o |-> done_o);
  // R6
  count_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_we_o |-> (cur_x_o != 16'd0) && (cur_y_o != 16'd0));
endmodule

bind dma_desc_loader dma_desc_loader_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .mem_req_o  (mem_req_o),
  .mem_ack_i  (mem_ack_i),
  .mem_addr_o (mem_addr_o),
  .prm_we_o   (prm_we_o),
  .cur_we_o   (cur_we_o),
  .cur_x_o    (cur_x_o),
  .cur_y_o    (cur_y_o),
  .done_o     (done_o)
);

// File: tb/tb_dma_desc_loader.sv
module tb_dma_desc_loader;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] cfg_i = '0;
  logic [31:0] next_ptr_i = '0, cur_ptr_i = '0, start_addr_i = '0;
  logic [15:0] x_count_i = '0, y_count_i = '0;
  logic        mem_req_o, mem_ack_i = 1'b0;
  logic [31:0] mem_addr_o;
  logic [15:0] mem_rdata_i = '0;
  logic [8:0]  prm_we_o;
  logic [15:0] prm_wdata_o;
  logic        cur_we_o, err_o, done_o;
  logic [31:0] cur_desc_ptr_o, cur_addr_o;
  logic [15:0] cur_x_o, cur_y_o;

  int n_chk = 0, n_err = 0;
  bit prev_err = 0;

  always #4 clk_i = ~clk_i;

  dma_desc_loader dut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] memf(input logic [31:0] a);
    memf = (a[15:0] * 16'd40503) ^ a[31:16] ^ 16'h5A3C;
  endfunction

  function automatic int tgt_of(input int fl, input int k);
    if (fl == 4)      tgt_of = k;
    else if (fl == 3) tgt_of = (k == 0) ? 0 : k + 1;
    else              tgt_of = k + 2;
  endfunction

  function automatic logic [15:0] mkcfg(input int fl, input int nd, input int ws);
    mkcfg = {1'b0, 3'(fl), 4'(nd), 4'b0000, 2'(ws), 2'b01};
  endfunction

  task automatic run_desc(input logic [15:0] cfg, input logic [31:0] np, cp, sa,
                          input logic [15:0] xc, yc, input bit poke);
    int fl = int'(cfg[14:12]);
    int nd = int'(cfg[11:8]);
    int ws = int'(cfg[3:2]);
    bit legal;
    logic [31:0] base, e_ndp, e_sa;
    logic [15:0] e_xc, e_yc;
    logic [1:0] mask;
    bit e_err, got_done, seen_req;
    int nstb, acked, last_stb;
    case (fl)
      0, 1: legal = (nd == 0);
      2: legal = (nd >= 1 && nd <= 7);
      3: legal = (nd >= 1 && nd <= 8);
      4: legal = (nd >= 1 && nd <= 9);
      default: legal = 0;
    endcase
    base = (fl == 2) ? cp : np;
    e_ndp = np; e_sa = sa; e_xc = xc; e_yc = yc;
    if (legal) begin
      for (int k = 0; k < nd; k++) begin
        logic [15:0] d = memf(base + 32'(2 * k));
        case (tgt_of(fl, k))
          0: e_ndp[15:0] = d;
          1: e_ndp[31:16] = d;
          2: e_sa[15:0] = d;
          3: e_sa[31:16] = d;
          5: e_xc = d;
          7: e_yc = d;
          default: ;
        endcase
      end
    end
    mask = (ws == 2) ? 2'b11 : (ws == 1) ? 2'b01 : 2'b00;
    e_err = !legal || ((e_sa[1:0] & mask) != 0);

    @(negedge clk_i);
    cfg_i = cfg; next_ptr_i = np; cur_ptr_i = cp; start_addr_i = sa;
    x_count_i = xc; y_count_i = yc; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    got_done = 0; seen_req = 0; nstb = 0; acked = 0; last_stb = 0;
    for (int c = 1; c <= 80; c++) begin
      if (prm_we_o != '0) begin
        chk(prm_we_o == 9'(1 << tgt_of(fl, nstb)), "R5", "strobe bit", 32'(prm_we_o), 32'(1 << tgt_of(fl, nstb)));
        chk(prm_wdata_o == memf(base + 32'(2 * nstb)), "R5", "strobe data", 32'(prm_wdata_o), 32'(memf(base + 32'(2 * nstb))));
        nstb++;
        last_stb = c;
      end
      if (mem_req_o) begin
        if (!seen_req)
          chk(mem_addr_o == base + 32'(2 * acked), "R4", "read address", mem_addr_o, base + 32'(2 * acked));
        seen_req = 1;
      end
      if (done_o) begin
        got_done = 1;
        chk(err_o == e_err, legal ? "R7" : "R2", "error flag", 32'(err_o), 32'(e_err));
        if (prev_err && !e_err) chk(err_o == 1'b0, "R9", "error cleared", 32'(err_o), 32'd0);
        chk(cur_we_o == legal, "R10", "cur strobe with done", 32'(cur_we_o), 32'(legal));
        chk(nstb == (legal ? nd : 0), "R5", "strobe count", 32'(nstb), 32'(legal ? nd : 0));
        if (!legal) begin
          chk(c == 1, "R2", "refusal latency", 32'(c), 32'd1);
          chk(!seen_req, "R2", "no request", 32'(seen_req), 32'd0);
        end else if (nd == 0) begin
          chk(c == 2, "R3", "zero-length latency", 32'(c), 32'd2);
          chk(!seen_req, "R3", "no request", 32'(seen_req), 32'd0);
        end else begin
          chk(c == last_stb + 1, "R10", "done after last strobe", 32'(c), 32'(last_stb + 1));
        end
        if (legal) begin
          chk(cur_desc_ptr_o == e_ndp, "R6", "cur desc ptr", cur_desc_ptr_o, e_ndp);
          chk(cur_addr_o == e_sa, "R6", "cur addr", cur_addr_o, e_sa);
          chk(cur_x_o == ((e_xc == 0) ? 16'hFFFF : e_xc), "R6", "cur x", 32'(cur_x_o), 32'((e_xc == 0) ? 16'hFFFF : e_xc));
          chk(cur_y_o == ((e_yc == 0) ? 16'hFFFF : e_yc), "R6", "cur y", 32'(cur_y_o), 32'((e_yc == 0) ? 16'hFFFF : e_yc));
        end
        mem_ack_i = 1'b0;
        break;
      end
      // R8: a second start mid-fetch with different inputs must change nothing
      if (poke && c == 2) begin
        start_i = 1'b1; cfg_i = 16'h7F0C; next_ptr_i = 32'h1357_9BDF; cur_ptr_i = 32'h2468_ACE0;
        start_addr_i = 32'h3; x_count_i = 16'h0; y_count_i = 16'h0;
      end else begin
        start_i = 1'b0;
      end
      mem_ack_i = mem_req_o && ($urandom % 4 != 0);
      mem_rdata_i = mem_ack_i ? memf(mem_addr_o) : 16'hDEAD;
      if (mem_ack_i) begin
        acked++;
        seen_req = 0;
      end
      @(negedge clk_i);
    end
    chk(got_done, poke ? "R8" : "R10", "done seen", 32'(got_done), 32'd1);
    @(negedge clk_i);
    chk(done_o == 1'b0 && cur_we_o == 1'b0, "R10", "single pulse", {30'd0, done_o, cur_we_o}, 32'd0);
    prev_err = e_err;
  endtask

  initial begin
    void'($urandom(32'd91));
    repeat (3) @(negedge clk_i);
    chk(mem_req_o == 0 && prm_we_o == 0 && cur_we_o == 0 && done_o == 0 && err_o == 0,
        "R1", "outputs in reset", {mem_req_o, prm_we_o, cur_we_o, done_o, err_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(mem_req_o == 0 && prm_we_o == 0 && done_o == 0 && err_o == 0,
        "R1", "outputs after reset", {mem_req_o, prm_we_o, done_o, err_o}, 32'd0);

    run_desc(mkcfg(0, 0, 2), 32'h100, 32'h200, 32'h1000, 16'd5, 16'd0, 0);         // R3 stop, Y 0 -> FFFF
    run_desc(mkcfg(1, 0, 0), 32'h100, 32'h200, 32'h1001, 16'd0, 16'd3, 0);         // R3 auto, X 0
    run_desc(mkcfg(0, 1, 0), 32'h100, 32'h200, 32'h1000, 16'd1, 16'd1, 0);         // R2 stop with count
    run_desc(mkcfg(0, 0, 2), 32'h100, 32'h200, 32'h1000, 16'd4, 16'd4, 0);         // R9 clear
    run_desc(mkcfg(2, 7, 1), 32'h4000, 32'h8000, 32'h10, 16'd2, 16'd2, 0);         // R4 array from cur ptr
    run_desc(mkcfg(2, 8, 1), 32'h4000, 32'h8000, 32'h10, 16'd2, 16'd2, 0);         // R2 array too long
    run_desc(mkcfg(3, 1, 0), 32'hA000, 32'hB000, 32'h22, 16'd9, 16'd9, 0);         // R5 small ptr low only
    run_desc(mkcfg(3, 8, 2), 32'hA100, 32'hB000, 32'h22, 16'd9, 16'd9, 0);
    run_desc(mkcfg(4, 9, 2), 32'hC000, 32'hD000, 32'h0, 16'd1, 16'd1, 0);          // R5 large full
    run_desc(mkcfg(4, 0, 0), 32'hC000, 32'hD000, 32'h0, 16'd1, 16'd1, 0);          // R2 large empty
    run_desc(mkcfg(6, 2, 0), 32'hC000, 32'hD000, 32'h0, 16'd1, 16'd1, 0);          // R2 undefined flow
    run_desc(mkcfg(0, 0, 2), 32'h0, 32'h0, 32'h2002, 16'd7, 16'd7, 0);             // R7 32-bit misaligned
    run_desc(mkcfg(1, 0, 1), 32'h0, 32'h0, 32'h2002, 16'd7, 16'd7, 0);             // R7 16-bit aligned
    run_desc(mkcfg(1, 0, 3), 32'h0, 32'h0, 32'h2003, 16'd7, 16'd7, 0);             // R7 8-bit
    run_desc(mkcfg(4, 5, 0), 32'hE000, 32'hF000, 32'h4, 16'd3, 16'd3, 1);          // R8 restart ignored

    for (int i = 0; i < 60; i++) begin
      int fl = ($urandom % 10 < 8) ? int'($urandom % 5) : int'($urandom % 8);
      int nd;
      if ($urandom % 5 == 0) nd = int'($urandom % 16);
      else if (fl < 2 || fl > 4) nd = 0;
      else nd = 1 + int'($urandom % ((fl == 2) ? 7 : (fl == 3) ? 8 : 9));
      run_desc(mkcfg(fl, nd, int'($urandom % 4)), $urandom, $urandom, $urandom,
               16'($urandom % 3 == 0 ? 0 : $urandom), 16'($urandom % 3 == 0 ? 0 : $urandom),
               (nd >= 2 && fl >= 2 && fl <= 4 && nd <= 7) ? bit'($urandom % 2) : 1'b0);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule